// File: doc/BRIEF.md
# Direction-select SPI slave

This block is an SPI slave (mode 0, most significant bit first) with a receive queue and a transmit queue, both 16 bytes deep. The master's SCLK, MOSI and chip select are resynchronised into the system clock, so the block runs entirely on `clk`. Each chip-select frame is half duplex. The least significant bit of the frame's first byte selects the direction. If that bit is 0, the frame is a write: every later MOSI byte is stored in the receive queue and MISO stays quiet. If it is 1, the frame is a read: queued transmit bytes are shifted out on MISO and MOSI is ignored.

The host side has a control word, a byte push port for the transmit queue and a pop port for the receive queue. A status word reports how full each queue is, and whether the last push was accepted. The break control bit is accepted but does nothing. To empty the transmit queue, clear the transmit-enable bit and then set it again.

Top module: `spi_dirsel_slave`

## Requirements
- R1: After reset, `status` is 0, and `miso` and `miso_oe` are both 0.
- R2: A frame whose first byte has LSB 0 is a write frame. The block samples MOSI on rising SCLK, MSB first, and pushes each complete later byte into the receive queue in arrival order. The direction byte itself is not stored. `rx_rdata` shows the oldest byte, and a one-cycle `rx_re` removes it.
- R3: Throughout a write frame, `miso` and `miso_oe` stay 0.
- R4: A frame whose first byte has LSB 1 is a read frame. MISO reads 0x00 during the direction byte. From the second byte on, transmit-queue bytes appear MSB first, each bit valid before the rising SCLK edge that samples it. `miso_oe` is 1 during the data bytes.
- R5: MOSI data in a read frame never enters the receive queue.
- R6: When the transmit queue is empty during a read-frame byte, that byte reads 0x00.
- R7: `status[4:0]` holds the receive-queue count and `status[9:5]` the transmit-queue count. `status[14:10]` holds the number of bytes accepted by the last `tx_we` push, which is 1 or 0.
- R8: A push to a full (16-byte) transmit queue is dropped, and the accepted field reads 0. The queued bytes keep their order.
- R9: Write-frame bytes that arrive while the receive queue holds 16 bytes are discarded. The 16 stored bytes are kept.
- R10: The break bit (control bit 2) has no effect on reception or transmission.
- R11: A control write that takes the transmit-enable bit from 0 to 1 empties the transmit queue and clears the transmit shifter. A later read frame then returns 0x00.
- R12: Raising chip select in the middle of a byte discards the partial byte. The next frame starts again with a direction byte.
- R13: Control bits are: 0 enable, 1 SPI mode, 2 break, 3 receive enable, 4 transmit enable. The slave takes part in frames only when bits 0 and 1 are both set; otherwise it stores nothing and MISO reads 0. With bit 3 clear, write-frame bytes are discarded. With bit 4 clear, read frames read 0x00 and the transmit queue is not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock from master (asynchronous) |
| mosi | input | 1 | SPI data from master |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to master |
| miso_oe | output | 1 | High while MISO carries read-frame data |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 5 | New control word |
| tx_we | input | 1 | Push one byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push |
| rx_re | input | 1 | Pop the oldest receive-queue byte |
| rx_rdata | output | 8 | Oldest receive-queue byte |
| status | output | 15 | Accepted count, transmit count, receive count |

## Verification
The assertions assume that SCLK, MOSI and chip select change slowly compared with `clk`. Each SCLK level must last several system clocks, so that the synchronised copies see every edge and MOSI has settled before the synchronised rising edge. The bench's SPI master holds each SCLK phase for eight system clocks and changes MOSI only while SCLK is low. It changes chip select only while SCLK is low. It never pushes, pops or writes control during a frame, so host actions and shift-register updates do not coincide.

// File: rtl/spi_ds_pkg.sv
// Shared constants and types for the direction-select SPI slave.
// Assumes nothing beyond being compiled before the modules that import it.
package spi_ds_pkg;
    localparam int CTRL_W   = 5;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_SPI = 1;
    localparam int CTRL_BRK = 2;
    localparam int CTRL_RXE = 3;
    localparam int CTRL_TXE = 4;

    typedef enum logic [1:0] {
        PH_DIR   = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;
endpackage

// File: rtl/spi_ds_sync.sv
// Multi-stage flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independently meaningful (no multi-bit coherency needed).
module spi_ds_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d};
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_ds_fifo.sv
// Synchronous byte queue with flush, drop-on-full push and ignore-on-empty pop.
// Assumes flush has priority over push and pop in the same cycle.
module spi_ds_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              accepted
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && !empty && !flush;
    assign accepted = do_push;
    assign rdata    = mem[rd_ptr];

    // Store pushed bytes.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers and occupancy; flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count)); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R11
endmodule

// File: rtl/spi_ds_engine.sv
// Frame engine: decodes the direction byte, deserializes write frames and
// serializes read frames. Mode 0, MSB first.
// Assumes synchronized inputs and SCLK levels lasting several clk cycles.
module spi_ds_engine
    import spi_ds_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              tx_flush,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_n_s,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_wdata,
    output logic              tx_pop,
    input  logic [DATA_W-1:0] tx_head,
    input  logic              tx_empty,
    output logic              miso,
    output logic              miso_oe
);
    phase_e            phase;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rxsh;
    logic [DATA_W-1:0] txsh;
    logic              sclk_d;
    logic              sclk_rise;
    logic              frame_on;
    logic              last_bit;
    logic              tx_avail;
    logic [DATA_W-1:0] tx_byte;

    assign frame_on  = active && !cs_n_s;
    assign sclk_rise = sclk_s && !sclk_d;
    assign last_bit  = (bit_cnt == BIT_W'(DATA_W - 1));
    assign tx_avail  = tx_en && !tx_empty;
    assign tx_byte   = tx_avail ? tx_head : '0;
    assign rx_wdata  = {rxsh, mosi_s};

    // Remember the previous synchronized SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Track frame phase, bit position and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            phase   <= PH_DIR;
            bit_cnt <= '0;
            rxsh    <= '0;
            txsh    <= '0;
        end else begin
            if (tx_flush) txsh <= '0;
            if (sclk_rise) begin
                rxsh    <= {rxsh[DATA_W-3:0], mosi_s};
                bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                if (phase == PH_READ) begin
                    if (bit_cnt == '0) txsh <= {tx_byte[DATA_W-2:0], 1'b0};
                    else               txsh <= {txsh[DATA_W-2:0], 1'b0};
                end
                if (last_bit && phase == PH_DIR) begin
                    phase <= mosi_s ? PH_READ : PH_WRITE;
                end
            end
        end
    end

    // Handshakes toward the queues.
    assign rx_push = frame_on && sclk_rise && last_bit && rx_en && (phase == PH_WRITE);
    assign tx_pop  = frame_on && sclk_rise && (bit_cnt == '0) && tx_avail && (phase == PH_READ);

    // Drive MISO only with read-frame data.
    always_comb begin
        miso_oe = frame_on && (phase == PH_READ);
        if (!miso_oe)            miso = 1'b0;
        else if (bit_cnt == '0)  miso = tx_byte[DATA_W-1];
        else                     miso = txsh[DATA_W-1];
    end

    AST_WRITE_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |-> (!miso && !miso_oe)); // R3
    AST_DIR_MISO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DIR) |-> !miso); // R4
    AST_READ_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ) |-> !rx_push); // R5
    AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |=> (phase == PH_DIR && bit_cnt == '0)); // R12
endmodule

// File: rtl/spi_dirsel_slave.sv
// Top level: control register, synchronizers, frame engine, two queues, status.
// Assumes the host does not touch the queues or control while a frame is active.
module spi_dirsel_slave
    import spi_ds_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
    localparam int STAT_W = 3 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    output logic              miso_oe,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_re,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [STAT_W-1:0] status
);
    logic              en_q, spi_q, rxe_q, txe_q;
    logic              tx_flush;
    logic [CNT_W-1:0]  last_acc;
    logic              sclk_s, mosi_s, cs_n_s;
    logic              rx_push, tx_pop;
    logic [DATA_W-1:0] rx_wdata, tx_head;
    logic [CNT_W-1:0]  rx_count, tx_count;
    logic              rx_full, rx_empty, rx_acc;
    logic              tx_full, tx_empty, tx_acc;

    // The transmit queue is flushed when transmit-enable goes from 0 to 1.
    assign tx_flush = ctrl_we && ctrl_wdata[CTRL_TXE] && !txe_q;

    // Hold the functional control bits; the break bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {en_q, spi_q, rxe_q, txe_q} <= '0;
        end else if (ctrl_we) begin
            en_q  <= ctrl_wdata[CTRL_EN];
            spi_q <= ctrl_wdata[CTRL_SPI];
            rxe_q <= ctrl_wdata[CTRL_RXE];
            txe_q <= ctrl_wdata[CTRL_TXE];
        end
    end

    // Record how many bytes the latest push placed in the transmit queue.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_acc <= '0;
        else if (tx_we) last_acc <= tx_acc ? CNT_W'(1) : '0;
    end

    spi_ds_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, mosi, sclk}),
        .q     ({cs_n_s, mosi_s, sclk_s})
    );

    spi_ds_engine #(.DATA_W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (en_q && spi_q),
        .rx_en    (rxe_q),
        .tx_en    (txe_q),
        .tx_flush (tx_flush),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .cs_n_s   (cs_n_s),
        .rx_push  (rx_push),
        .rx_wdata (rx_wdata),
        .tx_pop   (tx_pop),
        .tx_head  (tx_head),
        .tx_empty (tx_empty),
        .miso     (miso),
        .miso_oe  (miso_oe)
    );

    spi_ds_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (1'b0),
        .push     (rx_push),
        .wdata    (rx_wdata),
        .pop      (rx_re),
        .rdata    (rx_rdata),
        .count    (rx_count),
        .full     (rx_full),
        .empty    (rx_empty),
        .accepted (rx_acc)
    );

    spi_ds_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_flush),
        .push     (tx_we),
        .wdata    (tx_wdata),
        .pop      (tx_pop),
        .rdata    (tx_head),
        .count    (tx_count),
        .full     (tx_full),
        .empty    (tx_empty),
        .accepted (tx_acc)
    );

    assign status = {last_acc, tx_count, rx_count};

    AST_RX_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_re) |-> !rx_acc); // R9
    AST_RX_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_re && rx_empty && !rx_push) |=> (rx_count == '0)); // R2
    AST_TX_FULL_NOACC: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we && tx_full && !tx_pop) |=> (last_acc == '0)); // R8
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_count != '0)); // R6
    AST_BREAK_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[CTRL_BRK] && (ctrl_wdata[CTRL_TXE] == txe_q)) |-> !tx_flush); // R10
endmodule

// File: tb/tb_spi_dirsel_slave.sv
module tb_spi_dirsel_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8 * CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        miso, miso_oe;
    logic        ctrl_we = 1'b0;
    logic [4:0]  ctrl_wdata = '0;
    logic        tx_we = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic        rx_re = 1'b0;
    logic [7:0]  rx_rdata;
    logic [14:0] status;

    int checks = 0;
    int errors = 0;
    logic [7:0] mo [0:31];
    logic [7:0] mi [0:31];
    logic [7:0] exp_q [$];
    bit wr_mon = 0, rd_mon = 0;
    int wr_bad = 0;
    bit rd_oe_seen = 0;
    bit done = 0;

    spi_dirsel_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .miso_oe(miso_oe), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re), .rx_rdata(rx_rdata),
        .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor MISO activity during frames, sampled away from the active edge.
    always @(negedge clk) begin
        if (wr_mon && (miso !== 1'b0 || miso_oe !== 1'b0)) wr_bad++;
        if (rd_mon && miso_oe === 1'b1) rd_oe_seen = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [4:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_we = 1'b1; tx_wdata = b;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            #(HALF);
            r[i] = miso;
            sclk = 1'b1;
            #(HALF);
            sclk = 1'b0;
        end
    endtask

    // Driver/monitor for one frame; bytes from index chk_from are scored.
    task automatic run_frame(input int n, input int chk_from, input string tag);
        logic [7:0] r;
        cs_n = 1'b0;
        #(HALF);
        for (int b = 0; b < n; b++) begin
            send_byte(mo[b], 8, r);
            mi[b] = r;
            if (chk_from > 0 && b >= chk_from) begin
                if (exp_q.size() == 0) chk({tag, " queue underrun"}, 1, 0);
                else chk(tag, r, exp_q.pop_front());
            end
        end
        #(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        #(4*HALF);
    endtask

    // Scoreboard drain of the receive queue.
    task automatic drain_rx(input string tag);
        while (status[4:0] != 0) begin
            @(negedge clk);
            if (exp_q.size() == 0) chk({tag, " unexpected rx byte"}, rx_rdata, 0);
            else chk(tag, rx_rdata, exp_q.pop_front());
            rx_re = 1'b1;
            @(negedge clk);
            rx_re = 1'b0;
        end
        chk({tag, " leftover expected"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 0);
        chk("R1 miso", miso, 0);
        chk("R1 miso_oe", miso_oe, 0);

        set_ctrl(5'h1B);

        // R2/R3 write frame
        mo[0] = 8'h00; mo[1] = 8'hA5; mo[2] = 8'h3C; mo[3] = 8'h81;
        exp_q.push_back(8'hA5); exp_q.push_back(8'h3C); exp_q.push_back(8'h81);
        wr_mon = 1; run_frame(4, 0, "R2"); wr_mon = 0;
        chk("R2 R7 rx count", status[4:0], 3);
        chk("R3 miso quiet", wr_bad, 0);
        drain_rx("R2 rx data");

        // R4/R5/R6/R7 read frame
        push_tx(8'hDE); push_tx(8'hAD); push_tx(8'hBE);
        chk("R7 tx count", status[9:5], 3);
        chk("R7 accepted", status[14:10], 1);
        exp_q.push_back(8'hDE); exp_q.push_back(8'hAD); exp_q.push_back(8'hBE);
        exp_q.push_back(8'h00);
        mo[0] = 8'h01; mo[1] = 8'hFF; mo[2] = 8'h55; mo[3] = 8'hAA; mo[4] = 8'h0F;
        rd_mon = 1; run_frame(5, 1, "R4 R6 read byte"); rd_mon = 0;
        chk("R4 direction byte miso", mi[0], 0);
        chk("R4 miso_oe seen", rd_oe_seen, 1);
        chk("R5 rx untouched", status[4:0], 0);
        chk("R6 tx drained", status[9:5], 0);

        // R8 full transmit queue
        for (int i = 0; i < 17; i++) push_tx(8'(8'h10 + i));
        chk("R8 tx count", status[9:5], 16);
        chk("R8 accepted", status[14:10], 0);
        mo[0] = 8'h01;
        for (int i = 1; i < 17; i++) begin
            mo[i] = 8'h00;
            exp_q.push_back(8'(8'h10 + i - 1));
        end
        run_frame(17, 1, "R8 order");

        // R11 flush by toggling transmit enable
        push_tx(8'h77); push_tx(8'h88);
        set_ctrl(5'h0B);
        chk("R11 kept while off", status[9:5], 2);
        set_ctrl(5'h1B);
        chk("R11 flushed", status[9:5], 0);
        mo[0] = 8'h01; mo[1] = 8'h00; mo[2] = 8'h00;
        exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        run_frame(3, 1, "R11 zero out");

        // R9 full receive queue
        mo[0] = 8'h00;
        for (int i = 1; i < 19; i++) mo[i] = 8'(8'h40 + i);
        for (int i = 1; i < 17; i++) exp_q.push_back(8'(8'h40 + i));
        run_frame(19, 0, "R9");
        chk("R9 rx count", status[4:0], 16);
        drain_rx("R9 rx data");

        // R10 break bit inert
        set_ctrl(5'h1F);
        mo[0] = 8'h00; mo[1] = 8'hC3;
        exp_q.push_back(8'hC3);
        run_frame(2, 0, "R10");
        drain_rx("R10 rx data");
        push_tx(8'h3E);
        mo[0] = 8'h01; mo[1] = 8'h00;
        exp_q.push_back(8'h3E);
        run_frame(2, 1, "R10 read");
        set_ctrl(5'h1B);

        // R12 chip select dropped mid-byte
        cs_n = 1'b0; #(HALF);
        send_byte(8'h00, 8, r);
        send_byte(8'hF0, 4, r);
        #(HALF); cs_n = 1'b1; #(4*HALF);
        chk("R12 partial discarded", status[4:0], 0);
        mo[0] = 8'h00; mo[1] = 8'h5A;
        exp_q.push_back(8'h5A);
        run_frame(2, 0, "R12");
        drain_rx("R12 restart");

        // R13 receive enable off, enable off, SPI mode off
        set_ctrl(5'h13);
        mo[0] = 8'h00; mo[1] = 8'h11; mo[2] = 8'h22;
        run_frame(3, 0, "R13");
        chk("R13 rx disabled", status[4:0], 0);
        set_ctrl(5'h1A);
        push_tx(8'h99);
        mo[0] = 8'h01; mo[1] = 8'h00;
        exp_q.push_back(8'h00);
        run_frame(2, 1, "R13 disabled miso");
        chk("R13 tx kept", status[9:5], 1);
        set_ctrl(5'h19);
        mo[0] = 8'h00; mo[1] = 8'h66;
        run_frame(2, 0, "R13");
        chk("R13 spi mode off", status[4:0], 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule